// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block gathers interrupt requests from a set of internal sources and seven external lines. It presents the single most urgent one to the processor as a 3-bit level and a vector number. Each internal source holds three settings, written through a simple configuration port: a level from 1 to 7, a priority within that level, and a mask bit. The external lines have fixed settings.

Arbitration happens in two stages. The highest level among eligible sources is chosen first. Within that level, the highest priority wins. The processor supplies its current mask level, which filters what is presented. When the processor acknowledges, the vector of the winning source is captured and returned one cycle later.

Top module: `leveled_irq_ctrl`

## Requirements
- R1: After reset every internal source is masked, with level 1 and priority 0. Internal requests alone therefore present level 0 until they are configured.
- R2: A cycle with `cfg_we` high writes `cfg_level`, `cfg_prio` and `cfg_mask` into source `cfg_idx`, taking effect from the next cycle. An index of `N_INT` or more changes nothing.
- R3: `irq_level` is the highest level among eligible requests. The level of internal source i is its programmed level.
- R4: Among eligible requests at the winning level, the highest priority value wins. Among internal sources with equal level and priority, the lowest index wins.
- R5: External line j (0..6) has fixed level j+1. It outranks every internal source at that level, so `ext_req[6]` always yields level 7.
- R6: An internal source whose mask bit is 1 never takes part in arbitration.
- R7: A request is eligible only if its level is greater than `cpu_mask`. The exception is level 7, which is always eligible.
- R8: An internal source programmed to level 0 never takes part in arbitration.
- R9: With no eligible request, `irq_level` is 0.
- R10: In the cycle after `irq_ack` is high, `ack_valid` is 1 and `ack_vec` holds the winner's vector as it stood when the acknowledge was sampled. That vector is `VEC_BASE+i` for internal source i, `VEC_BASE+N_INT+j` for external line j, or `VEC_SPUR` when nothing was eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | CIDX_W | Internal source index to configure |
| cfg_level | input | 3 | Level to write (0 disables) |
| cfg_prio | input | PRIO_W | Priority to write |
| cfg_mask | input | 1 | Mask bit to write (1 = masked) |
| int_req | input | N_INT | Internal request lines |
| ext_req | input | 7 | External request lines |
| cpu_mask | input | 3 | Processor's current mask level |
| irq_ack | input | 1 | Acknowledge strobe |
| irq_level | output | 3 | Level of the presented request, 0 if none |
| ack_valid | output | 1 | Vector return valid |
| ack_vec | output | VEC_W | Returned vector number |

## Verification
The hardest situation to reach is a three-way contest inside one level. In it, an external line, two internal sources with equal priority, and a masked source of higher priority all compete while the processor mask sits just below that level. Directed stimulus programs such a level step by step. It then flips one mask bit or request at a time and acknowledges after each change. A long random phase follows, with sparse requests, random reconfiguration (including out-of-range indices and level 0) and random mask levels. A behavioural model compares the results on every cycle.

// File: rtl/leveled_irq_ctrl.sv
module leveled_irq_ctrl #(
  parameter int N_INT    = 63,
  parameter int PRIO_W   = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_SPUR = 24,
  localparam int CIDX_W  = $clog2(N_INT + 1),
  localparam int KEY_W   = 4 + PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CIDX_W-1:0] cfg_idx,
  input  logic [2:0]        cfg_level,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              cfg_mask,
  input  logic [N_INT-1:0]  int_req,
  input  logic [6:0]        ext_req,
  input  logic [2:0]        cpu_mask,
  input  logic              irq_ack,
  output logic [2:0]        irq_level,
  output logic              ack_valid,
  output logic [VEC_W-1:0]  ack_vec
);

  logic [2:0]        lvl_q  [N_INT];
  logic [PRIO_W-1:0] prio_q [N_INT];
  logic [N_INT-1:0]  msk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msk_q <= '1;
      for (int i = 0; i < N_INT; i++) begin
        lvl_q[i]  <= 3'd1;
        prio_q[i] <= '0;
      end
    end else if (cfg_we && (int'(cfg_idx) < N_INT)) begin
      lvl_q[cfg_idx]  <= cfg_level;
      prio_q[cfg_idx] <= cfg_prio;
      msk_q[cfg_idx]  <= cfg_mask;
    end
  end

  logic [KEY_W-1:0] best_key;
  logic [VEC_W-1:0] best_vec;
  logic             found;

  always_comb begin
    logic [KEY_W-1:0] k;
    logic [2:0]       lv;
    best_key = '0;
    best_vec = VEC_W'(VEC_SPUR);
    found    = 1'b0;
    for (int i = 0; i < N_INT; i++) begin
      lv = lvl_q[i];
      k  = {lv, 1'b0, prio_q[i]};
      if (int_req[i] && !msk_q[i] && lv != 3'd0 && (lv == 3'd7 || lv > cpu_mask)
          && (!found || k > best_key)) begin
        best_key = k;
        best_vec = VEC_W'(VEC_BASE + i);
        found    = 1'b1;
      end
    end
    for (int j = 0; j < 7; j++) begin
      lv = 3'(j + 1);
      k  = {lv, 1'b1, {PRIO_W{1'b1}}};
      if (ext_req[j] && (lv == 3'd7 || lv > cpu_mask) && (!found || k > best_key)) begin
        best_key = k;
        best_vec = VEC_W'(VEC_BASE + N_INT + j);
        found    = 1'b1;
      end
    end
  end

  assign irq_level = found ? best_key[KEY_W-1 -: 3] : 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack_vec   <= '0;
    end else begin
      ack_valid <= irq_ack;
      if (irq_ack) ack_vec <= best_vec;
    end
  end

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req == '0 && ext_req == '0) |-> irq_level == 3'd0);
  assert_ack_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> ack_valid);
  assert_above_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level != 3'd0 |-> (irq_level == 3'd7 || irq_level > cpu_mask));
  assert_ext_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req[6] |-> irq_level == 3'd7);
  assert_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && $past(rst_n) && $past(irq_level) != 3'd0) |-> ack_vec != VEC_W'(VEC_SPUR));

endmodule

// File: tb/sim_leveled_irq_ctrl.sv
module sim_leveled_irq_ctrl;
  localparam int N = 63;
  localparam int BASE = 64;
  localparam int SPUR = 24;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_mask = 0, irq_ack = 0;
  logic [5:0] cfg_idx = 0;
  logic [2:0] cfg_level = 0, cpu_mask = 0;
  logic [3:0] cfg_prio = 0;
  logic [N-1:0] int_req = '0;
  logic [6:0] ext_req = '0;
  logic [2:0] irq_level;
  logic ack_valid;
  logic [7:0] ack_vec;

  leveled_irq_ctrl u0 (.clk, .rst_n, .cfg_we, .cfg_idx, .cfg_level, .cfg_prio, .cfg_mask,
    .int_req, .ext_req, .cpu_mask, .irq_ack, .irq_level, .ack_valid, .ack_vec);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int m_lvl [N];
  int m_pri [N];
  bit m_msk [N];
  string tag = "R1";
  bit exp_av = 0;
  int exp_vec = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic model(output int lv, output int vec);
    lv = 0; vec = SPUR;
    for (int l = 7; l >= 1 && lv == 0; l--) begin
      if (l != 7 && l <= cpu_mask) continue;
      if (ext_req[l-1]) begin lv = l; vec = BASE + N + l - 1; end
      else begin
        int bp = -1;
        for (int i = 0; i < N; i++)
          if (int_req[i] && !m_msk[i] && m_lvl[i] == l && m_pri[i] > bp) begin
            bp = m_pri[i]; vec = BASE + i; lv = l;
          end
      end
    end
  endtask

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    int lv, vec;
    model(lv, vec);
    exp_av = irq_ack;
    if (irq_ack) exp_vec = vec;
    if (cfg_we && cfg_idx < N) begin
      m_lvl[cfg_idx] = cfg_level; m_pri[cfg_idx] = cfg_prio; m_msk[cfg_idx] = cfg_mask;
    end
    @(negedge clk);
    model(lv, vec);
    chk("irq_level", irq_level, lv);
    chk("ack_valid", ack_valid, exp_av);
    if (exp_av) chk("ack_vec", ack_vec, exp_vec);
  endtask

  task automatic cfg(int idx, int l, int p, bit m);
    cfg_we = 1; cfg_idx = 6'(idx); cfg_level = 3'(l); cfg_prio = 4'(p); cfg_mask = m;
    tick();
    cfg_we = 0;
  endtask

  task automatic ack();
    irq_ack = 1; tick(); irq_ack = 0; tick();
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_lvl[i] = 1; m_pri[i] = 0; m_msk[i] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; int_req = '1; tick(); tick(); ack();
    tag = "R2"; cfg(5, 3, 2, 0); tick(); cfg(63, 7, 15, 0); ack();
    int_req = '0; int_req[5] = 1; int_req[10] = 1; int_req[11] = 1; int_req[12] = 1;
    tag = "R3"; cfg(10, 5, 2, 0); ack();
    tag = "R4"; cfg(11, 5, 9, 0); cfg(12, 5, 9, 0); ack(); int_req[11] = 0; ack(); int_req[11] = 1;
    tag = "R6"; cfg(11, 5, 9, 1); ack();
    tag = "R5"; ext_req[4] = 1; ack(); ext_req[1] = 1; ack(); ext_req[6] = 1; ack();
    tag = "R7"; ext_req = '0; cpu_mask = 5; ack(); cpu_mask = 4; ack(); cpu_mask = 7; ext_req[6] = 1; ack();
    ext_req = '0; cpu_mask = 0;
    tag = "R8"; cfg(12, 0, 15, 0); ack(); cfg(10, 0, 3, 0); ack();
    tag = "R9"; int_req = '0; ack();
    tag = "R10";
    for (int c = 0; c < 6000; c++) begin
      for (int i = 0; i < N; i++) int_req[i] = ($urandom % 6) == 0;
      for (int j = 0; j < 7; j++) ext_req[j] = ($urandom % 20) == 0;
      if ($urandom % 8 == 0) cpu_mask = 3'($urandom);
      irq_ack = ($urandom % 3) == 0;
      cfg_we = ($urandom % 2) == 0;
      cfg_idx = 6'($urandom); cfg_level = 3'($urandom); cfg_prio = 4'($urandom);
      cfg_mask = ($urandom % 4) == 0;
      tick();
    end
    cfg_we = 0; irq_ack = 0; int_req = '0; ext_req = '0;
    tag = "R9"; tick(); tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule